// File: doc/BRIEF.md
# Precision Time Event Timestamp Latch

This block freezes the current 64-bit time of day when a precision time protocol event packet is detected. It works on the receive path and on the transmit path. A packet parser elsewhere raises a one-cycle event strobe for each direction. With the strobe it supplies two vectors: the detection rules that matched the packet and the packet parameters that matched. When the event qualifies, the block copies the time input into a one-entry buffer for that direction and sets a valid flag.

The buffer is sticky. Once it holds a value, later events cannot overwrite it. Software reads the value and then writes a 1 back into the valid flag position, which empties the buffer for the next capture.

Each direction has its own enable field, 14-bit rule mask and 11-bit parameter mask. A set mask bit hides the corresponding match bit. Software uses a simple word-addressed read/write port to configure the block and to collect timestamps. Read data is returned one cycle after the read strobe.

Top module: `ptp_ts_capture`

## Requirements
- R1: After reset, both buffers are empty and their timestamps read 0. Every enable field reads 0, every rule mask reads 0x3FFF, every parameter mask reads 0x7FF, and `reg_rdata` is 0.
- R2: A capture happens when all of the following hold on a strobe: the buffer is empty, the enable is nonzero, at least one match bit is set at a position where the rule mask holds 0, and at least one parameter bit is set at a position where the parameter mask holds 0. On a capture, the buffer stores the `time_now` value present at that clock edge, and its valid flag (bit 16 of the status word) reads 1 from then on.
- R3: With the enable field at 0, no strobe captures anything, whatever the masks and match vectors.
- R4: No strobe captures anything when either of these holds: every set match bit is masked (so a rule mask of 0x3FFF blocks all captures), or every set parameter bit is masked (so a parameter mask of 0x7FF blocks all captures).
- R5: While the valid flag is set, strobes are ignored, and the stored timestamp and the flag stay unchanged.
- R6: A write to the status word with bit 16 at 1 empties the buffer. A status write with bit 16 at 0 has no effect.
- R7: In a cycle that carries both a re-arm write and a strobe, the buffer's state before that edge decides the outcome. A full buffer ends empty and the strobe is lost. An empty buffer captures the strobe.
- R8: The receive and transmit directions are independent. Strobes, configuration writes and re-arm writes for one direction never change the other direction's registers.
- R9: Address bit 3 selects the direction (0 = receive, 1 = transmit). Address bits 2:0 select the word within the direction: 0 = status, 1 = timestamp bits 31:0, 2 = timestamp bits 63:32, 3 = enable in bits 2:0, 4 = rule mask in bits 13:0, 5 = parameter mask in bits 10:0. Unused bits read 0, and writes to the timestamp words are ignored.
- R10: `reg_rdata` is updated one cycle after a read strobe and holds its value when there is no read. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address (direction in bit 3, offset in bits 2:0) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| time_now | input | 64 | Current time from the time counter |
| rx_evt | input | 1 | Receive-side event strobe |
| rx_rule_hits | input | 14 | Receive-side matched detection rules |
| rx_param_hits | input | 11 | Receive-side matched packet parameters |
| tx_evt | input | 1 | Transmit-side event strobe |
| tx_rule_hits | input | 14 | Transmit-side matched detection rules |
| tx_param_hits | input | 11 | Transmit-side matched packet parameters |

## Verification
A corrupted valid flag shows up at the next read of the status word. It also changes behaviour on the next strobe: a flag stuck at 1 blocks captures, and a flag stuck at 0 lets a later strobe overwrite a held timestamp. That second fault becomes visible as a changed timestamp word on the following read. A wrong mask or enable value can be seen directly on readback, one cycle after the read strobe. Its effect on qualification appears only when a strobe arrives whose match vector reaches the affected bit. For that reason, the stimulus sweeps many combinations of mask and match bits and reads the buffers back every few cycles.

// File: rtl/ptp_ts_pkg.sv
`timescale 1ns/1ps
package ptp_ts_pkg;
  localparam int DATA_W      = 32;
  localparam int TIME_W      = 64;
  localparam int RULE_W      = 14;
  localparam int PARAM_W     = 11;
  localparam int EN_W        = 3;
  localparam int OFS_W       = 3;
  localparam int VALID_BIT   = 16;
  // word offsets inside one direction
  localparam int OFS_STAT    = 0;
  localparam int OFS_TS_LO   = 1;
  localparam int OFS_TS_HI   = 2;
  localparam int OFS_ENABLE  = 3;
  localparam int OFS_RMASK   = 4;
  localparam int OFS_PMASK   = 5;
endpackage

// File: rtl/ptp_ts_match.sv
`timescale 1ns/1ps
module ptp_ts_match #(
  parameter int RULE_W  = 14,
  parameter int PARAM_W = 11,
  parameter int EN_W    = 3
) (
  input  logic [EN_W-1:0]    en,
  input  logic [RULE_W-1:0]  rmask,
  input  logic [PARAM_W-1:0] pmask,
  input  logic [RULE_W-1:0]  rule_hits,
  input  logic [PARAM_W-1:0] param_hits,
  output logic               hit
);
  logic rule_any, param_any;

  // a set mask bit hides the matching hit bit
  assign rule_any  = |(rule_hits & ~rmask);
  assign param_any = |(param_hits & ~pmask);
  assign hit       = (en != '0) && rule_any && param_any;
endmodule

// File: rtl/ptp_ts_slot.sv
`timescale 1ns/1ps
module ptp_ts_slot
  import ptp_ts_pkg::*;
#(
  parameter int RULE_W   = ptp_ts_pkg::RULE_W,
  parameter int PARAM_W  = ptp_ts_pkg::PARAM_W,
  parameter int EN_W     = ptp_ts_pkg::EN_W,
  parameter int TIME_W   = ptp_ts_pkg::TIME_W,
  parameter int DATA_W   = ptp_ts_pkg::DATA_W,
  parameter int SLOT_OFS = ptp_ts_pkg::OFS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [SLOT_OFS-1:0] cfg_ofs,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                evt,
  input  logic [RULE_W-1:0]   rule_hits,
  input  logic [PARAM_W-1:0]  param_hits,
  input  logic [TIME_W-1:0]   time_now,
  output logic [EN_W-1:0]     en_q,
  output logic [RULE_W-1:0]   rmask_q,
  output logic [PARAM_W-1:0]  pmask_q,
  output logic                valid_q,
  output logic [TIME_W-1:0]   ts_q,
  output logic                rearm
);
  localparam logic [RULE_W-1:0]  RMASK_RST = '1;
  localparam logic [PARAM_W-1:0] PMASK_RST = '1;

  logic qual, take;
  logic wr_stat, wr_en, wr_rm, wr_pm;
  logic unused_wbits;

  ptp_ts_match #(
    .RULE_W (RULE_W),
    .PARAM_W(PARAM_W),
    .EN_W   (EN_W)
  ) u_match (
    .en        (en_q),
    .rmask     (rmask_q),
    .pmask     (pmask_q),
    .rule_hits (rule_hits),
    .param_hits(param_hits),
    .hit       (qual)
  );

  assign wr_stat = cfg_we && (cfg_ofs == SLOT_OFS'(OFS_STAT));
  assign wr_en   = cfg_we && (cfg_ofs == SLOT_OFS'(OFS_ENABLE));
  assign wr_rm   = cfg_we && (cfg_ofs == SLOT_OFS'(OFS_RMASK));
  assign wr_pm   = cfg_we && (cfg_ofs == SLOT_OFS'(OFS_PMASK));
  assign rearm   = wr_stat && cfg_wdata[VALID_BIT];
  assign unused_wbits = ^cfg_wdata;

  // qualification uses the configuration held before this edge
  assign take = evt && qual && !valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rmask_q <= RMASK_RST;
      pmask_q <= PMASK_RST;
    end else begin
      if (wr_en) en_q    <= cfg_wdata[EN_W-1:0];
      if (wr_rm) rmask_q <= cfg_wdata[RULE_W-1:0];
      if (wr_pm) pmask_q <= cfg_wdata[PARAM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ts_q    <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      ts_q    <= time_now;
    end else if (rearm) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ptp_ts_readmux.sv
`timescale 1ns/1ps
module ptp_ts_readmux
  import ptp_ts_pkg::*;
#(
  parameter int RULE_W   = ptp_ts_pkg::RULE_W,
  parameter int PARAM_W  = ptp_ts_pkg::PARAM_W,
  parameter int EN_W     = ptp_ts_pkg::EN_W,
  parameter int TIME_W   = ptp_ts_pkg::TIME_W,
  parameter int DATA_W   = ptp_ts_pkg::DATA_W,
  parameter int SLOT_OFS = ptp_ts_pkg::OFS_W
) (
  input  logic [SLOT_OFS-1:0] ofs,
  input  logic                valid,
  input  logic [TIME_W-1:0]   ts,
  input  logic [EN_W-1:0]     en,
  input  logic [RULE_W-1:0]   rmask,
  input  logic [PARAM_W-1:0]  pmask,
  output logic [DATA_W-1:0]   word
);
  localparam int HALF = TIME_W / 2;

  always_comb begin
    word = '0;
    case (int'(ofs))
      OFS_STAT:   word[VALID_BIT] = valid;
      OFS_TS_LO:  word = DATA_W'(ts[HALF-1:0]);
      OFS_TS_HI:  word = DATA_W'(ts[TIME_W-1:HALF]);
      OFS_ENABLE: word = DATA_W'(en);
      OFS_RMASK:  word = DATA_W'(rmask);
      OFS_PMASK:  word = DATA_W'(pmask);
      default:    word = '0;
    endcase
  end
endmodule

// File: rtl/ptp_ts_capture.sv
`timescale 1ns/1ps
module ptp_ts_capture
  import ptp_ts_pkg::*;
#(
  parameter int RULE_W   = ptp_ts_pkg::RULE_W,
  parameter int PARAM_W  = ptp_ts_pkg::PARAM_W,
  parameter int EN_W     = ptp_ts_pkg::EN_W,
  parameter int TIME_W   = ptp_ts_pkg::TIME_W,
  parameter int DATA_W   = ptp_ts_pkg::DATA_W,
  parameter int SLOT_OFS = ptp_ts_pkg::OFS_W,
  localparam int NUM_DIR = 2,
  localparam int DIR_W   = $clog2(NUM_DIR),
  localparam int ADDR_W  = SLOT_OFS + DIR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [TIME_W-1:0]  time_now,
  input  logic               rx_evt,
  input  logic [RULE_W-1:0]  rx_rule_hits,
  input  logic [PARAM_W-1:0] rx_param_hits,
  input  logic               tx_evt,
  input  logic [RULE_W-1:0]  tx_rule_hits,
  input  logic [PARAM_W-1:0] tx_param_hits
);
  logic [NUM_DIR-1:0]              evt_v;
  logic [NUM_DIR-1:0][RULE_W-1:0]  rule_v;
  logic [NUM_DIR-1:0][PARAM_W-1:0] param_v;

  logic [NUM_DIR-1:0]              slot_valid;
  logic [NUM_DIR-1:0]              slot_rearm;
  logic [NUM_DIR-1:0][TIME_W-1:0]  slot_ts;
  logic [NUM_DIR-1:0][EN_W-1:0]    slot_en;
  logic [NUM_DIR-1:0][RULE_W-1:0]  slot_rmask;
  logic [NUM_DIR-1:0][PARAM_W-1:0] slot_pmask;
  logic [NUM_DIR-1:0][DATA_W-1:0]  slot_word;

  logic [DIR_W-1:0]    sel_dir;
  logic [SLOT_OFS-1:0] sel_ofs;

  assign evt_v   = {tx_evt, rx_evt};
  assign rule_v  = {tx_rule_hits, rx_rule_hits};
  assign param_v = {tx_param_hits, rx_param_hits};
  assign sel_dir = reg_addr[ADDR_W-1:SLOT_OFS];
  assign sel_ofs = reg_addr[SLOT_OFS-1:0];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic dir_we;
    assign dir_we = reg_wr_en && (sel_dir == DIR_W'(d));

    ptp_ts_slot #(
      .RULE_W  (RULE_W),
      .PARAM_W (PARAM_W),
      .EN_W    (EN_W),
      .TIME_W  (TIME_W),
      .DATA_W  (DATA_W),
      .SLOT_OFS(SLOT_OFS)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (dir_we),
      .cfg_ofs   (sel_ofs),
      .cfg_wdata (reg_wdata),
      .evt       (evt_v[d]),
      .rule_hits (rule_v[d]),
      .param_hits(param_v[d]),
      .time_now  (time_now),
      .en_q      (slot_en[d]),
      .rmask_q   (slot_rmask[d]),
      .pmask_q   (slot_pmask[d]),
      .valid_q   (slot_valid[d]),
      .ts_q      (slot_ts[d]),
      .rearm     (slot_rearm[d])
    );

    ptp_ts_readmux #(
      .RULE_W  (RULE_W),
      .PARAM_W (PARAM_W),
      .EN_W    (EN_W),
      .TIME_W  (TIME_W),
      .DATA_W  (DATA_W),
      .SLOT_OFS(SLOT_OFS)
    ) u_rmux (
      .ofs  (sel_ofs),
      .valid(slot_valid[d]),
      .ts   (slot_ts[d]),
      .en   (slot_en[d]),
      .rmask(slot_rmask[d]),
      .pmask(slot_pmask[d]),
      .word (slot_word[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= slot_word[sel_dir];
  end
endmodule

// File: rtl/ptp_ts_capture_chk.sv
`timescale 1ns/1ps
module ptp_ts_capture_chk #(
  parameter int NUM_DIR = 2,
  parameter int TIME_W  = 64,
  parameter int EN_W    = 3,
  parameter int DATA_W  = 32
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             reg_rd_en,
  input logic [DATA_W-1:0]                reg_rdata,
  input logic [TIME_W-1:0]                time_now,
  input logic [NUM_DIR-1:0]               slot_valid,
  input logic [NUM_DIR-1:0]               slot_rearm,
  input logic [NUM_DIR-1:0][TIME_W-1:0]   slot_ts,
  input logic [NUM_DIR-1:0][EN_W-1:0]     slot_en
);
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (slot_valid == '0) && (reg_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_rd_en && !rst) |=> $stable(reg_rdata));

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_chk
    // R2
    capture_time_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(slot_valid[d]) |-> slot_ts[d] == $past(time_now));

    // R3
    capture_enabled_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(slot_valid[d]) |-> $past(slot_en[d]) != '0);

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_valid[d] && !slot_rearm[d]) |=> slot_valid[d] && $stable(slot_ts[d]));

    // R7
    rearm_full_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_valid[d] && slot_rearm[d]) |=> !slot_valid[d]);
  end
endmodule

bind ptp_ts_capture ptp_ts_capture_chk #(
  .NUM_DIR(2),
  .TIME_W (TIME_W),
  .EN_W   (EN_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rd_en (reg_rd_en),
  .reg_rdata (reg_rdata),
  .time_now  (time_now),
  .slot_valid(slot_valid),
  .slot_rearm(slot_rearm),
  .slot_ts   (slot_ts),
  .slot_en   (slot_en)
);

// File: tb/ptp_ts_capture_bench.sv
`timescale 1ns/1ps
module ptp_ts_capture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_now = 64'h0000_0010_0000_0100;
  logic        rx_evt = 1'b0, tx_evt = 1'b0;
  logic [13:0] rx_rule_hits = '0, tx_rule_hits = '0;
  logic [10:0] rx_param_hits = '0, tx_param_hits = '0;

  int total = 0;
  int fails = 0;

  // model state, index 0 = receive, 1 = transmit
  logic [2:0]  m_en [2];
  logic [13:0] m_rm [2];
  logic [10:0] m_pm [2];
  logic        m_val[2];
  logic [63:0] m_ts [2];

  always #2 clk = ~clk;  // 250 MHz

  always @(negedge clk) time_now <= time_now + 64'h0000_0001_0000_0007;

  ptp_ts_capture u_ptp_ts_capture (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_now(time_now),
    .rx_evt(rx_evt), .rx_rule_hits(rx_rule_hits), .rx_param_hits(rx_param_hits),
    .tx_evt(tx_evt), .tx_rule_hits(tx_rule_hits), .tx_param_hits(tx_param_hits)
  );

  function automatic logic qualifies(logic [2:0] en, logic [13:0] rm, logic [10:0] pm,
                                     logic [13:0] rh, logic [10:0] ph);
    return (en != 0) && ((rh & ~rm) != 0) && ((ph & ~pm) != 0);
  endfunction

  function automatic logic [31:0] expect_word(logic [3:0] a);
    int d = int'(a[3]);
    case (a[2:0])
      3'd0: return {15'd0, m_val[d], 16'd0};
      3'd1: return m_ts[d][31:0];
      3'd2: return m_ts[d][63:32];
      3'd3: return {29'd0, m_en[d]};
      3'd4: return {18'd0, m_rm[d]};
      3'd5: return {21'd0, m_pm[d]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_en[d] = 0; m_rm[d] = 14'h3FFF; m_pm[d] = 11'h7FF; m_val[d] = 0; m_ts[d] = 0;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one clock with optional events and an optional write; called at a negedge
  task automatic cycle(logic ev0, logic [13:0] rh0, logic [10:0] ph0,
                       logic ev1, logic [13:0] rh1, logic [10:0] ph1,
                       logic we, logic [3:0] wa, logic [31:0] wd);
    logic        cap [2];
    logic        rearm [2];
    logic [63:0] tcap;
    rx_evt = ev0; rx_rule_hits = rh0; rx_param_hits = ph0;
    tx_evt = ev1; tx_rule_hits = rh1; tx_param_hits = ph1;
    reg_wr_en = we; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    tcap = time_now;
    cap[0] = ev0 && !m_val[0] && qualifies(m_en[0], m_rm[0], m_pm[0], rh0, ph0);
    cap[1] = ev1 && !m_val[1] && qualifies(m_en[1], m_rm[1], m_pm[1], rh1, ph1);
    for (int d = 0; d < 2; d++) begin
      rearm[d] = 0;
      if (we && int'(wa[3]) == d) begin
        case (wa[2:0])
          3'd0: rearm[d] = wd[16];
          3'd3: m_en[d] = wd[2:0];
          3'd4: m_rm[d] = wd[13:0];
          3'd5: m_pm[d] = wd[10:0];
          default: ;
        endcase
      end
      if (cap[d]) begin m_val[d] = 1; m_ts[d] = tcap; end
      else if (rearm[d]) m_val[d] = 0;
    end
    @(negedge clk);
    rx_evt = 0; tx_evt = 0; reg_wr_en = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cycle(0, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic rd_chk(string req, logic [3:0] a);
    reg_rd_en = 1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd_en = 0;
    check(req, reg_rdata, expect_word(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values, R10 unmapped offsets
    check("R1 rdata", reg_rdata, 32'd0);
    for (int a = 0; a < 16; a++) rd_chk((a % 8) > 5 ? "R10" : "R1", 4'(a));

    // R4 default masks block capture
    cycle(1, 14'h3FFF, 11'h7FF, 1, 14'h3FFF, 11'h7FF, 0, 0, 0);
    rd_chk("R4", 4'h0); check("R4 rx empty", reg_rdata, 32'd0);
    rd_chk("R4", 4'h8);

    // configure receive direction
    wr(4'h3, 32'd5); wr(4'h4, 32'h3FF7); wr(4'h5, 32'h7FE);
    // R2 capture
    cycle(1, 14'h0008, 11'h001, 0, 0, 0, 0, 0, 0);
    rd_chk("R2", 4'h0); check("R2 flag", reg_rdata, 32'h0001_0000);
    rd_chk("R2", 4'h1); rd_chk("R2", 4'h2);
    rd_chk("R8", 4'h8);
    // R5 sticky
    cycle(1, 14'h0008, 11'h001, 0, 0, 0, 0, 0, 0);
    rd_chk("R5", 4'h1); rd_chk("R5", 4'h2); rd_chk("R5", 4'h0);
    // R6 write 0 is no-op, write 1 re-arms
    wr(4'h0, 32'h0000_FFFF); rd_chk("R6", 4'h0); check("R6 kept", reg_rdata, 32'h0001_0000);
    wr(4'h0, 32'h0001_0000); rd_chk("R6", 4'h0); check("R6 cleared", reg_rdata, 32'd0);
    // R4 masked rule / masked parameter
    cycle(1, 14'h0001, 11'h001, 0, 0, 0, 0, 0, 0); rd_chk("R4", 4'h0);
    cycle(1, 14'h0008, 11'h002, 0, 0, 0, 0, 0, 0); rd_chk("R4", 4'h0);
    // R3 enable zero
    wr(4'h3, 32'd0);
    cycle(1, 14'h3FFF, 11'h7FF, 0, 0, 0, 0, 0, 0); rd_chk("R3", 4'h0);
    check("R3 empty", reg_rdata, 32'd0);
    wr(4'h3, 32'hFFFF_FFF1); rd_chk("R9", 4'h3); check("R9 enable width", reg_rdata, 32'd1);
    // R8 transmit independent
    wr(4'hB, 32'd7); wr(4'hC, 32'h0); wr(4'hD, 32'h0);
    cycle(0, 0, 0, 1, 14'h2000, 11'h400, 0, 0, 0);
    rd_chk("R8", 4'h8); rd_chk("R8", 4'h9); rd_chk("R8", 4'hA); rd_chk("R8", 4'h0);
    // R7 full buffer + re-arm + event -> empty
    cycle(0, 0, 0, 1, 14'h0001, 11'h001, 1, 4'h8, 32'h0001_0000);
    rd_chk("R7", 4'h8); check("R7 lost", reg_rdata, 32'd0);
    // R7 empty buffer + re-arm + event -> captured
    cycle(0, 0, 0, 1, 14'h0001, 11'h001, 1, 4'h8, 32'h0001_0000);
    rd_chk("R7", 4'h8); check("R7 taken", reg_rdata, 32'h0001_0000);
    rd_chk("R7", 4'h9);
    // R9 timestamp words read-only
    wr(4'h9, 32'hDEAD_BEEF); wr(4'hA, 32'hCAFE_F00D);
    rd_chk("R9", 4'h9); rd_chk("R9", 4'hA);
    // R10 hold without read
    held = reg_rdata;
    repeat (5) cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R10 hold", reg_rdata, held);

    // constrained random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [13:0] rh0, rh1;
      logic [10:0] ph0, ph1;
      logic        we;
      logic [3:0]  wa;
      logic [31:0] wd;
      rh0 = 14'($urandom); rh1 = 14'($urandom);
      ph0 = 11'($urandom); ph1 = 11'($urandom);
      we = ($urandom % 3) == 0;
      wa = {1'($urandom), 3'($urandom % 6)};
      case ($urandom % 4)
        0: wd = 32'h0001_0000;
        1: wd = 32'h0;
        2: wd = 32'hFFFF_FFFF;
        default: wd = $urandom & 32'h0001_3FFF;
      endcase
      cycle(1'($urandom), rh0, ph0, 1'($urandom), rh1, ph1, we, wa, wd);
      if (i % 4 == 3) rd_chk("R2 random", 4'($urandom));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule